// File: doc/BRIEF.md
# Reloadable Bit-Rate Divider with Count Readback

This block divides the system clock down to the bit-rate tick for a serial receiver and transmitter. A 16-bit counter counts down toward zero. When it is at zero it picks up a stored reload value on the next clock, and it emits a single-cycle tick. Software writes the reload value one byte at a time. Writing the low byte also restarts the count at once from the full value, so a new rate takes effect without waiting for the old period to end.

One control bit sets what a byte read returns: the stored reload value or the live count. The live count is read one byte at a time with no holding register. The two halves therefore come from different clock cycles if the count moves between the reads. When the receiver is switched off, the same control bit also turns the divider into a periodic interrupt timer. An interrupt pulse then comes out alongside every tick. While the receiver is on, the bit affects readback only.

Top module: `baud_gen_rb`

## Requirements
- R1: While reset is asserted, the reload value, the count and the control bit are zero, and tick and irq are low. Reads of either byte return 0 during reset.
- R2: In a cycle with no low-byte write and a nonzero count, the count decreases by exactly one at the next clock.
- R3: In a cycle with the count at zero and no low-byte write, the count takes the stored reload value at the next clock. The tick output is high for exactly the one cycle after each cycle in which the count was zero. A nonzero reload value N therefore gives a tick period of N+1 clocks.
- R4: A stored reload value of zero is loaded as 1. The tick then repeats every 2 clocks and never stalls.
- R5: A write with reg_sel=0 (low byte) stores reg_wdata as bits 7:0 of the reload value. At the same clock the count is loaded with {stored high byte, reg_wdata}. This takes priority over decrement and reload.
- R6: A write with reg_sel=1 (high byte) stores reg_wdata as bits 15:8 of the reload value and leaves the count untouched.
- R7: With the control bit at 0, reg_rdata returns bits 7:0 (reg_sel=0) or bits 15:8 (reg_sel=1) of the stored reload value, combinationally.
- R8: With the control bit at 1, reg_rdata returns the selected byte of the live count, combinationally and without latching the other byte.
- R9: With rx_en=0 and the control bit at 1 in a cycle where the count is zero, irq pulses high in the next cycle, together with tick.
- R10: irq stays low after any cycle in which rx_en=1 or the control bit is 0.
- R11: A clock edge with ctrl_we=1 sets the control bit to ctrl_d. The new value steers readback from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Byte write strobe |
| reg_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected byte |
| ctrl_we | input | 1 | Control bit write strobe |
| ctrl_d | input | 1 | Control bit write value (1 = live count view and timer interrupt) |
| rx_en | input | 1 | Receiver enable |
| tick | output | 1 | One-cycle bit-rate tick |
| irq | output | 1 | One-cycle timer interrupt pulse |

## Verification
A wrong count shows up as a tick out of place within one reload period, and with the live view selected it appears on reg_rdata in the very next cycle. A faulty stored reload value appears directly when the reload view is selected, and as a wrong tick period after the next zero. A gating error on the interrupt produces a stray or missing irq pulse on the first zero after rx_en or the control bit changes. The reference model is therefore compared against every output on every clock.

// File: rtl/bg_pkg.sv
package bg_pkg;

   // Readback view selected by the control bit.
   typedef enum logic {
      VIEW_RELOAD = 1'b0,
      VIEW_COUNT  = 1'b1
   } bg_view_e;

   // Byte lane whose write restarts the counter.
   localparam int unsigned RESTART_LANE = 0;

endpackage

// File: rtl/bg_reload_regs.sv
module bg_reload_regs #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned NLANES = 2,
   parameter int unsigned LANE_W = 1,
   localparam int unsigned CNT_W = BUS_W * NLANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [LANE_W-1:0] sel,
   input  logic [BUS_W-1:0]  wdata,
   output logic [CNT_W-1:0]  reload,
   output logic [CNT_W-1:0]  load_val,
   output logic              restart
);
   import bg_pkg::*;

   assign restart = wr && (sel == LANE_W'(RESTART_LANE));

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      logic [BUS_W-1:0] lane_q;
      logic             lane_we;

      assign lane_we = wr && (sel == LANE_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       lane_q <= '0;
         else if (lane_we) lane_q <= wdata;
      end

      assign reload[g*BUS_W +: BUS_W] = lane_q;

      if (g == RESTART_LANE) begin : g_restart
         assign load_val[g*BUS_W +: BUS_W] = wdata;
      end else begin : g_keep
         assign load_val[g*BUS_W +: BUS_W] = lane_q;
      end
   end

   // A write to another lane leaves the restart lane unchanged.
   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !restart) |=> $stable(reload[RESTART_LANE*BUS_W +: BUS_W])) // R6
      else $error("high write altered low lane");

endmodule

// File: rtl/bg_counter.sv
module bg_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             zero,
   output logic             tick
);
   logic [CNT_W-1:0] reload_eff;
   logic [CNT_W-1:0] cnt_d;

   assign zero       = (cnt == '0);
   assign reload_eff = (reload == '0) ? CNT_W'(1) : reload;

   always_comb begin
      if (restart)   cnt_d = load_val;
      else if (zero) cnt_d = reload_eff;
      else           cnt_d = cnt - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         cnt  <= cnt_d;
         tick <= zero;
      end
   end

   AST_CNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !zero) |=> (cnt == $past(cnt) - CNT_W'(1))) // R2
      else $error("count did not decrement");

   AST_ZERO_NOT_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && zero) |=> (cnt != '0)) // R4
      else $error("count stalled at zero");

   AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == $past(load_val))) // R5
      else $error("low write did not load count");

   AST_TICK_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(zero)) // R3
      else $error("tick without zero");

endmodule

// File: rtl/bg_readmux.sv
module bg_readmux #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned NLANES = 2,
   parameter int unsigned LANE_W = 1,
   localparam int unsigned CNT_W = BUS_W * NLANES
) (
   input  bg_pkg::bg_view_e  view,
   input  logic [CNT_W-1:0]  reload,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [LANE_W-1:0] sel,
   output logic [BUS_W-1:0]  rdata
);
   import bg_pkg::*;

   logic [CNT_W-1:0] src;
   logic [BUS_W-1:0] lanes [NLANES];

   assign src = (view == VIEW_COUNT) ? cnt : reload;

   for (genvar g = 0; g < NLANES; g++) begin : g_slice
      assign lanes[g] = src[g*BUS_W +: BUS_W];
   end

   if (NLANES == (1 << LANE_W)) begin : g_full
      assign rdata = lanes[sel];
   end else begin : g_partial
      always_comb begin
         rdata = '0;
         for (int i = 0; i < NLANES; i++)
            if (sel == LANE_W'(i)) rdata = lanes[i];
      end
   end

endmodule

// File: rtl/bg_irq_gen.sv
module bg_irq_gen (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zero,
   input  bg_pkg::bg_view_e view,
   input  logic             rx_en,
   output logic             irq
);
   import bg_pkg::*;

   logic timer_mode;

   assign timer_mode = (view == VIEW_COUNT) && !rx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= zero && timer_mode;
   end

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(zero && !rx_en && (view == VIEW_COUNT))) // R9
      else $error("irq without timer-mode zero");

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en || (view == VIEW_RELOAD)) |=> !irq) // R10
      else $error("irq while gated off");

endmodule

// File: rtl/baud_gen_rb.sv
module baud_gen_rb #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned CNT_W  = 16,
   localparam int unsigned NLANES = CNT_W / BUS_W,
   localparam int unsigned LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [LANE_W-1:0] reg_sel,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic              ctrl_we,
   input  logic              ctrl_d,
   input  logic              rx_en,
   output logic              tick,
   output logic              irq
);
   import bg_pkg::*;

   if ((CNT_W % BUS_W) != 0 || NLANES < 2) begin : g_bad_width
      $error("CNT_W must be a multiple of BUS_W, at least two lanes");
   end

   bg_view_e         view_q;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt;
   logic             restart;
   logic             zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       view_q <= VIEW_RELOAD;
      else if (ctrl_we) view_q <= bg_view_e'(ctrl_d);
   end

   bg_reload_regs #(.BUS_W(BUS_W), .NLANES(NLANES), .LANE_W(LANE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .reload(reload), .load_val(load_val), .restart(restart)
   );

   bg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart), .load_val(load_val),
      .reload(reload), .cnt(cnt), .zero(zero), .tick(tick)
   );

   bg_readmux #(.BUS_W(BUS_W), .NLANES(NLANES), .LANE_W(LANE_W)) u_rd (
      .view(view_q), .reload(reload), .cnt(cnt), .sel(reg_sel), .rdata(reg_rdata)
   );

   bg_irq_gen u_irq (
      .clk(clk), .rst_n(rst_n), .zero(zero), .view(view_q), .rx_en(rx_en), .irq(irq)
   );

   AST_IRQ_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> tick) // R9
      else $error("irq without tick");

   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (view_q == bg_view_e'($past(ctrl_d)))) // R11
      else $error("control write lost");

endmodule

// File: tb/sim_baud_gen_rb.sv
`timescale 1ns/1ps
module sim_baud_gen_rb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [0:0] reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       ctrl_we = 1'b0;
   logic       ctrl_d = 1'b0;
   logic       rx_en = 1'b0;
   logic       tick;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   baud_gen_rb u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_we(ctrl_we),
      .ctrl_d(ctrl_d), .rx_en(rx_en), .tick(tick), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // Behavioural reference state
   int m_rel = 0;
   int m_cnt = 0;
   int m_view = 0;
   int m_tick = 0;
   int m_irq = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rel = 0; m_cnt = 0; m_view = 0; m_tick = 0; m_irq = 0;
      end else begin
         m_tick = (m_cnt == 0);
         m_irq  = (m_cnt == 0 && m_view == 1 && !rx_en);
         if (reg_wr && reg_sel == 1'b0)
            m_cnt = (m_rel & 'hFF00) | reg_wdata;
         else if (m_cnt == 0)
            m_cnt = (m_rel == 0) ? 1 : m_rel;
         else
            m_cnt = m_cnt - 1;
         if (reg_wr) begin
            if (reg_sel == 1'b1) m_rel = (m_rel & 'h00FF) | (int'(reg_wdata) << 8);
            else                 m_rel = (m_rel & 'hFF00) | reg_wdata;
         end
         if (ctrl_we) m_view = ctrl_d;
      end
   end

   // Compare every clock, 1 ns after the edge
   always begin
      @(posedge clk);
      #1;
      if (rst_n && !done) begin
         int src;
         int exp_rd;
         src = (m_view == 1) ? m_cnt : m_rel;
         exp_rd = (reg_sel == 1'b1) ? ((src >> 8) & 'hFF) : (src & 'hFF);
         chk((m_rel == 0) ? "R4 tick" : "R3 tick", int'(tick), m_tick);
         chk((m_view == 1) ? "R8 live count read" : "R7 reload read", int'(reg_rdata), exp_rd);
         chk((m_view == 1 && !rx_en) ? "R9 irq" : "R10 irq", int'(irq), m_irq);
      end
   end

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         reg_sel = ~reg_sel;
      end
   endtask

   task automatic wr_byte(input logic s, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_view(input logic v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_d = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      reg_sel = 1'b0; #1;
      chk("R1 low byte in reset", int'(reg_rdata), 0);
      reg_sel = 1'b1; #1;
      chk("R1 high byte in reset", int'(reg_rdata), 0);
      chk("R1 tick in reset", int'(tick), 0);
      chk("R1 irq in reset", int'(irq), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Reload 5, reload view, receiver off: no irq
      wr_byte(1'b1, 8'h00);
      wr_byte(1'b0, 8'h05);
      run(20);

      // R11: switch to live view, timer interrupts
      set_view(1'b1);
      run(20);

      // Receiver on: irq suppressed
      rx_en = 1'b1;
      run(20);

      // R6: high write leaves count untouched
      wr_byte(1'b1, 8'h12);
      reg_sel = 1'b1; #1;
      chk("R6 count high after high write", int'(reg_rdata), 0);
      set_view(1'b0);
      reg_sel = 1'b1; #1;
      chk("R11 view change to reload", int'(reg_rdata), 'h12);
      set_view(1'b1);

      // R5: low write restarts count, R2: decrement
      wr_byte(1'b0, 8'h34);
      reg_sel = 1'b1; #1;
      chk("R5 count high after low write", int'(reg_rdata), 'h12);
      reg_sel = 1'b0; #1;
      chk("R5 count low after low write", int'(reg_rdata), 'h34);
      @(negedge clk); #1;
      chk("R2 count low one clock later", int'(reg_rdata), 'h33);
      run(40);

      // R4: reload zero behaves as one
      rx_en = 1'b0;
      wr_byte(1'b1, 8'h00);
      wr_byte(1'b0, 8'h00);
      run(12);

      // Larger period, crossing the high byte, views alternating
      wr_byte(1'b1, 8'h01);
      wr_byte(1'b0, 8'h03);
      run(300);
      set_view(1'b0);
      run(300);
      set_view(1'b1);
      rx_en = 1'b1;
      run(100);
      rx_en = 1'b0;

      // Restarts at varied phases
      for (int k = 0; k < 12; k++) begin
         wr_byte(1'b0, 8'(k * 3 + 1));
         run(k + 2);
         if (k % 4 == 3) set_view(~ctrl_d);
      end
      run(30);
      @(negedge clk);
      finish_run();
   end
endmodule